// File: doc/BRIEF.md
# 24-bit SPI register slave with frame check

This block is the serial control port of a bridge pre-driver. A host drives chip select, a serial clock and a data line; the block samples all three into its own system clock and treats every chip-select-low window as one frame. A valid frame has exactly 24 serial clocks, most significant bit first: a command byte (two operation bits, six address bits) followed by 16 data bits. While the command byte arrives, the block returns a global status byte. During the data bits it returns the contents of the addressed register.

The block decodes four operations: write, read, read-and-clear and read-ID. They act on a control register, a status register, a config register and five 8-bit identification constants. Writes take effect only when chip select is released after a frame of exactly 24 clocks, and the write frame itself returns the old contents. A frame with any other non-zero clock count is dropped and reported in the next status byte. A chip-select pulse with no clocks is a fault poll: the data line shows the global fault flag, and the frame has no other effect. A frame of 24 ones acts as a soft reset.

Top module: `spi24_regs`

## Requirements
- R1: Data is sampled on rising serial-clock edges and response bits change after falling edges, both MSB first. `sdo_oe_o` is 0 whenever chip select is high.
- R2: While chip select is low and before the first rising clock, `sdo_o` shows the fault flag. The fault flag is TF or not-RESB or TSD or UOV_OC or NRDY.
- R3: The first response byte is, from bit 7 down to bit 0: fault flag, TF, RESB, `tsd_i`, 0, UOV_OC, 0, `nrdy_i`. With `nrdy_i`=1 it reads 81h after reset.
- R4: Operation code 00 writes. It returns the previous contents and commits at chip-select release. The control register is at address 00h and keeps only bits 9..6 and 4..0 (mask 03DFh), so other bits read as 0. The config register is at 3Fh and keeps bits 15..3 (mask FFF8h).
- R5: Operation code 01 reads. The status register is at address 10h. An unmapped address reads as 0. Writes to 10h or to unmapped addresses change nothing.
- R6: Operation code 10 on address 10h returns the status register and then clears it.
- R7: Operation code 11 returns an ID constant in data bits 15..8, with bits 7..0 at 0. The constants are 43h at 00h, 01h at 01h, 75h at 02h, 35h at 03h and 02h at 3Eh; every other address gives 0.
- R8: A frame whose clock count is neither 0 nor 24 has no effect except that it sets TF. TF is cleared at the end of the next 24-clock frame. A 0-clock poll does not set TF.
- R9: A 24-clock frame of all ones clears the control, config and status registers and sets RESB to 0.
- R10: RESB is 0 after reset and after a soft reset. It becomes 1 at the end of the next 24-clock frame.
- R11: Each bit of `stat_set_i` inside mask 01ECh sets the same status-register bit, which stays set until it is cleared. UOV_OC is the OR of the status register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| tsd_i | input | 1 | Thermal shutdown indication |
| nrdy_i | input | 1 | Not-ready indication |
| stat_set_i | input | 16 | Status event set pulses |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| ctrl_o | output | 16 | Control register contents |
| cfg_o | output | 16 | Config register contents |

## Verification
The decoder is exercised with every operation code against mapped, unmapped and ID addresses. All-ones, reserved-bit and back-to-back write data show that each value is masked and that the old value is returned. Frames of 12, 23 and 25 clocks, each followed by a read, separate dropped frames from committed ones and show when TF is set and cleared; a zero-clock poll confirms that polling leaves TF alone. Status events, thermal and not-ready inputs are applied one at a time, so the position of each status-byte bit and each contributor to the fault flag can be told apart. A soft reset is checked against a register file that was left non-zero.

// File: rtl/spi24_pkg.sv
package spi24_pkg;
  localparam int OP_W   = 2;
  localparam int ADDR_W = 6;
  localparam int CMD_W  = OP_W + ADDR_W;
  localparam int DATA_W = 16;

  typedef enum logic [OP_W-1:0] {
    OP_WR = 2'b00,
    OP_RD = 2'b01,
    OP_RC = 2'b10,
    OP_ID = 2'b11
  } spi_op_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h10;
  localparam logic [ADDR_W-1:0] A_CFG  = 6'h3F;

  localparam logic [DATA_W-1:0] CTRL_MASK = 16'h03DF;
  localparam logic [DATA_W-1:0] CFG_MASK  = 16'hFFF8;
  localparam logic [DATA_W-1:0] STAT_MASK = 16'h01EC;

  function automatic logic [7:0] id_value(logic [ADDR_W-1:0] a);
    case (a)
      6'h00:   return 8'h43;
      6'h01:   return 8'h01;
      6'h02:   return 8'h75;
      6'h03:   return 8'h35;
      6'h3E:   return 8'h02;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spi24_sync.sv
module spi24_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh <= RST_VAL[g];
        else         sh <= in_i[g];
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh <= {STAGES{RST_VAL[g]}};
        else         sh <= {sh[STAGES-2:0], in_i[g]};
    end
    assign lvl_o[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/spi24_frame.sv
module spi24_frame
  import spi24_pkg::*;
#(
  parameter int FRAME_W = CMD_W + DATA_W,
  parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_s_i,
  input  logic               sclk_s_i,
  input  logic               sdi_s_i,
  input  logic [CMD_W-1:0]   status_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               cs_rise_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CMD_W-1:0]   peek_o,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(CMD_W - 1);

  logic prev_cs_q, prev_sclk_q;
  logic cs_act, cs_fall, sclk_rise, sclk_fall;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_cs_q   <= 1'b1;
      prev_sclk_q <= 1'b0;
    end else begin
      prev_cs_q   <= csn_s_i;
      prev_sclk_q <= sclk_s_i;
    end

  assign cs_act    = ~csn_s_i;
  assign cs_rise_o = csn_s_i & ~prev_cs_q;
  assign cs_fall   = ~csn_s_i & prev_cs_q;
  assign sclk_rise = cs_act & sclk_s_i & ~prev_sclk_q;
  assign sclk_fall = cs_act & ~sclk_s_i & prev_sclk_q;

  // bit counter and receive shifter
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
    end else if (cs_rise_o || cs_fall) begin
      cnt_q <= '0;
    end else if (sclk_rise) begin
      rx_q <= {rx_q[FRAME_W-2:0], sdi_s_i};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end

  // response shifter: status at first edge, register data once the command is in
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      tx_q     <= '0;
      loaded_q <= 1'b0;
    end else if (cs_rise_o || cs_fall) begin
      loaded_q <= 1'b0;
    end else if (sclk_rise) begin
      if (cnt_q == '0) begin
        tx_q     <= {status_i, {DATA_W{1'b0}}};
        loaded_q <= 1'b1;
      end else if (cnt_q == CNT_DATA) begin
        tx_q[FRAME_W-2 -: DATA_W] <= rd_data_i;
      end
    end else if (sclk_fall && loaded_q) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end

  assign cnt_o    = cnt_q;
  assign frame_o  = rx_q;
  assign peek_o   = {rx_q[CMD_W-2:0], sdi_s_i};
  assign sdo_o    = loaded_q ? tx_q[FRAME_W-1] : status_i[CMD_W-1];
  assign sdo_oe_o = cs_act;
endmodule

// File: rtl/spi24_regfile.sv
module spi24_regfile
  import spi24_pkg::*;
#(
  parameter int FRAME_W = CMD_W + DATA_W,
  parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CMD_W-1:0]   peek_i,
  input  logic               tsd_i,
  input  logic               nrdy_i,
  input  logic [DATA_W-1:0]  stat_set_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [CMD_W-1:0]   status_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic [DATA_W-1:0]  cfg_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [DATA_W-1:0] ctrl_q, cfg_q, stat_q;
  logic              tf_q, resb_q;

  spi_op_e           p_op, f_op;
  logic [ADDR_W-1:0] p_addr, f_addr;
  logic [DATA_W-1:0] f_data;
  logic              full, ones, bad, wr_ok, clr_stat, uov, flt;

  assign p_op   = spi_op_e'(peek_i[CMD_W-1 -: OP_W]);
  assign p_addr = peek_i[ADDR_W-1:0];
  assign f_op   = spi_op_e'(frame_i[FRAME_W-1 -: OP_W]);
  assign f_addr = frame_i[FRAME_W-OP_W-1 -: ADDR_W];
  assign f_data = frame_i[DATA_W-1:0];

  always_comb begin
    rd_data_o = '0;
    if (p_op == OP_ID) begin
      rd_data_o = {id_value(p_addr), 8'h00};
    end else begin
      case (p_addr)
        A_CTRL:  rd_data_o = ctrl_q;
        A_STAT:  rd_data_o = stat_q;
        A_CFG:   rd_data_o = cfg_q;
        default: rd_data_o = '0;
      endcase
    end
  end

  assign full     = commit_i && (cnt_i == CNT_FULL);
  assign ones     = &frame_i;
  assign bad      = commit_i && (cnt_i != CNT_FULL) && (cnt_i != '0);
  assign wr_ok    = full && !ones && (f_op == OP_WR);
  assign clr_stat = full && (ones || (f_op == OP_RC && f_addr == A_STAT));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      stat_q <= '0;
      tf_q   <= 1'b0;
      resb_q <= 1'b0;
    end else begin
      if (bad)       tf_q <= 1'b1;
      else if (full) tf_q <= 1'b0;
      if (full) resb_q <= !ones;
      if (full && ones) begin
        ctrl_q <= '0;
        cfg_q  <= '0;
      end else if (wr_ok) begin
        if (f_addr == A_CTRL) ctrl_q <= f_data & CTRL_MASK;
        if (f_addr == A_CFG)  cfg_q  <= f_data & CFG_MASK;
      end
      // new events win over a same-cycle clear
      stat_q <= (clr_stat ? '0 : stat_q) | (stat_set_i & STAT_MASK);
    end

  assign uov      = |stat_q;
  assign flt      = tf_q | ~resb_q | tsd_i | uov | nrdy_i;
  assign status_o = {flt, tf_q, resb_q, tsd_i, 1'b0, uov, 1'b0, nrdy_i};
  assign ctrl_o   = ctrl_q;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/spi24_regs.sv
module spi24_regs
  import spi24_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              tsd_i,
  input  logic              nrdy_i,
  input  logic [DATA_W-1:0] stat_set_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cfg_o
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic [2:0]         pins_s;
  logic               cs_rise;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] frame_bits;
  logic [CMD_W-1:0]   peek_cmd, status_byte;
  logic [DATA_W-1:0]  rd_data;

  spi24_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({csn_i, sclk_i, sdi_i}),
    .lvl_o  (pins_s)
  );

  spi24_frame #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csn_s_i   (pins_s[2]),
    .sclk_s_i  (pins_s[1]),
    .sdi_s_i   (pins_s[0]),
    .status_i  (status_byte),
    .rd_data_i (rd_data),
    .cs_rise_o (cs_rise),
    .cnt_o     (bit_cnt),
    .frame_o   (frame_bits),
    .peek_o    (peek_cmd),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
  );

  spi24_regfile #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (cs_rise),
    .cnt_i      (bit_cnt),
    .frame_i    (frame_bits),
    .peek_i     (peek_cmd),
    .tsd_i      (tsd_i),
    .nrdy_i     (nrdy_i),
    .stat_set_i (stat_set_i),
    .rd_data_o  (rd_data),
    .status_o   (status_byte),
    .ctrl_o     (ctrl_o),
    .cfg_o      (cfg_o)
  );
endmodule

// File: rtl/spi24_chk.sv
module spi24_chk #(
  parameter int FRAME_W = 24,
  parameter int CNT_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               csn_i,
  input logic               sdo_o,
  input logic               sdo_oe_o,
  input logic [15:0]        ctrl_o,
  input logic [15:0]        cfg_o,
  input logic               cs_rise,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [FRAME_W-1:0] frame_bits,
  input logic               tf_i,
  input logic               flt_i
);
  // two-stage input synchroniser assumed
  assert_oe_needs_csn_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !$past(csn_i, 2));

  assert_poll_shows_flt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && bit_cnt == '0) |-> (sdo_o == flt_i));

  assert_regs_change_on_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_rise) |-> ($stable(ctrl_o) && $stable(cfg_o)));

  assert_tf_only_on_bad_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tf_i) |-> $past(cs_rise && bit_cnt != '0 && bit_cnt != CNT_W'(FRAME_W)));

  assert_all_ones_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_rise && bit_cnt == CNT_W'(FRAME_W) && (&frame_bits)) |-> (ctrl_o == '0 && cfg_o == '0));
endmodule

bind spi24_regs spi24_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .csn_i      (csn_i),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .ctrl_o     (ctrl_o),
  .cfg_o      (cfg_o),
  .cs_rise    (cs_rise),
  .bit_cnt    (bit_cnt),
  .frame_bits (frame_bits),
  .tf_i       (status_byte[6]),
  .flt_i      (status_byte[7])
);

// File: tb/spi24_regs_bench.sv
`timescale 1ns/1ps
module spi24_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0, tsd = 1'b0, nrdy = 1'b1;
  logic [15:0] sset = '0;
  logic sdo, oe;
  logic [15:0] ctrl, cfg;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [23:0] m;

  always #2.5 clk = ~clk;

  spi24_regs u_spi24_regs (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .tsd_i(tsd), .nrdy_i(nrdy), .stat_set_i(sset),
    .sdo_o(sdo), .sdo_oe_o(oe), .ctrl_o(ctrl), .cfg_o(cfg)
  );

  localparam int NV = 23;
  localparam logic [23:0] V_MOSI [NV] = '{
    24'hC00000, 24'hFE0000, 24'h00FFFF, 24'h400000, 24'h3F1234, 24'h3FABCF,
    24'h7F0000, 24'hC10000, 24'hC20000, 24'hC30000, 24'hC50000, 24'h10FFFF,
    24'h500000, 24'h000019, 24'h450000, 24'h400000, 24'h400000, 24'h400000,
    24'h000155, 24'h400000, 24'h000155, 24'h400000, 24'h400000};
  localparam int V_NCLK [NV] = '{
    24, 24, 24, 24, 24, 24, 24, 24, 24, 24, 24, 24,
    24, 24, 24, 12, 24, 24, 23, 24, 25, 24, 24};
  localparam logic [23:0] V_MISO [NV] = '{
    24'h204300, 24'h200200, 24'h200000, 24'h2003DF, 24'h200000, 24'h201230,
    24'h20ABC8, 24'h200100, 24'h207500, 24'h203500, 24'h200000, 24'h200000,
    24'h200000, 24'h2003DF, 24'h200000, 24'h000000, 24'hE00019, 24'h200019,
    24'h000000, 24'hE00019, 24'h000000, 24'hE00019, 24'h200019};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] mosi, input int nclk, output logic [23:0] miso);
    miso = '0;
    @(negedge clk) csn = 1'b0;
    wait_n(8);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 24) ? mosi[23-i] : 1'b0;
      wait_n(8);
      if (i < 24) miso[23-i] = sdo;
      sclk = 1'b1;
      wait_n(8);
      sclk = 1'b0;
    end
    wait_n(8);
    csn = 1'b0;
    csn = 1'b1;
    sdi = 1'b0;
    wait_n(10);
  endtask

  task automatic poll(input string tag, input logic exp);
    @(negedge clk) csn = 1'b0;
    wait_n(8);
    check({tag, " oe"}, oe, 1'b1);
    check(tag, sdo, exp);
    csn = 1'b1;
    wait_n(8);
    check({tag, " oe released R1"}, oe, 1'b0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 reset oe", oe, 1'b0);
    check("R4 reset ctrl", ctrl, 16'h0000);
    check("R4 reset cfg", cfg, 16'h0000);
    poll("R2 reset poll FLT", 1'b1);
    xfer(24'hC00000, 24, m);
    check("R3 R10 reset status byte", m, 24'h814300);
    nrdy = 1'b0;

    for (int i = 0; i < NV; i++) begin
      xfer(V_MOSI[i], V_NCLK[i], m);
      if (V_NCLK[i] == 24)
        check($sformatf("vector %0d R1 R4 R5 R7 R8", i), m, V_MISO[i]);
    end
    check("R4 ctrl after vectors", ctrl, 16'h0019);
    check("R4 cfg after vectors", cfg, 16'hABC8);

    // status events and read-and-clear
    @(negedge clk) sset = 16'h0026;
    @(negedge clk) sset = '0;
    wait_n(4);
    poll("R2 poll with status event", 1'b1);
    xfer(24'h500000, 24, m);
    check("R11 R3 status read", m, 24'hA40024);
    xfer(24'h900000, 24, m);
    check("R6 read-and-clear returns", m, 24'hA40024);
    xfer(24'h500000, 24, m);
    check("R6 status cleared", m, 24'h200000);
    poll("R2 poll no fault", 1'b0);

    // thermal flag
    tsd = 1'b1;
    wait_n(4);
    xfer(24'hC00000, 24, m);
    check("R3 thermal bit", m, 24'hB04300);
    tsd = 1'b0;
    wait_n(4);

    // poll does not set TF
    poll("R8 poll before read", 1'b0);
    xfer(24'h400000, 24, m);
    check("R8 poll leaves TF", m, 24'h200019);

    // soft reset
    xfer(24'h000155, 24, m);
    check("R4 write returns old", m, 24'h200019);
    check("R4 ctrl written", ctrl, 16'h0155);
    xfer(24'hFFFFFF, 24, m);
    check("R9 all-ones response", m, 24'h200000);
    check("R9 ctrl cleared", ctrl, 16'h0000);
    check("R9 cfg cleared", cfg, 16'h0000);
    xfer(24'h400000, 24, m);
    check("R10 RESB low after soft reset", m, 24'h800000);
    xfer(24'h7F0000, 24, m);
    check("R10 RESB back high, R9 cfg zero", m, 24'h200000);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule